// File: doc/BRIEF.md
# Immediate-OR Five-Stage Pipeline with Operand Forwarding

This block is a small in-order integer pipeline with five stages: fetch, decode, execute, memory and write-back. It runs a program held in an internal instruction ROM, which is set through a parameter. It recognises one instruction, a bitwise OR of a register with a zero-extended 16-bit immediate. Every other opcode passes through as a bubble. The block contains a 32-entry, 32-bit register file.

A result can be needed by a following instruction before it has been written back. The decode stage handles this by forwarding instead of stalling. Each source operand is taken from one of three places, in this order:
1. the instruction currently in execute,
2. the instruction currently in the memory stage,
3. the register file, which passes same-cycle write data straight through.

Chains of dependent instructions therefore issue one per cycle with no bubbles.

The block's only outputs are the write-back port and the program counter. A system or a testbench follows execution by watching which register is written, with what value, and in which cycle.

Top module: `pipe5_ori`

## Requirements
- R1: The opcode is in bits [31:26], and the value 6'b001101 selects the immediate-OR instruction. The source register index is in bits [25:21] and the destination index in bits [20:16]. The write-back value is the source register's architectural value ORed with the immediate in bits [15:0].
- R2: The immediate is zero-extended to 32 bits, so an immediate with bit 15 set adds no bits above bit 15 to the result.
- R3: A consumer issued in the cycle right after its producer receives the producer's result from the execute stage. When the execute and memory stages both hold a matching destination, the execute-stage value is the one used.
- R4: A consumer issued two instructions after its producer receives the producer's result from the memory stage.
- R5: A consumer issued three instructions after its producer reads the producer's result through the register file, which returns the write data for a read of the register being written in that same cycle.
- R6: Register 0 reads as zero. An immediate-OR whose destination is register 0 produces no write-back and changes no register.
- R7: An instruction with any opcode other than 6'b001101 produces no write-back and changes no register.
- R8: While reset is high, the PC is held at 0, every pipeline stage is emptied, no write-back is issued and every register is cleared to zero.
- R9: After reset the PC starts at 0 and rises by 4 on every clock. The instruction at word k, read from address PC[..:2], reaches the write-back port k+4 clocks after reset is released. Words beyond the end of the ROM read as zero, which is a bubble.
- R10: The four-instruction chain R1=R0|0x1100, R1|=0x0020, R1|=0x4400, R1|=0x0044 writes back 0x1100, 0x1120, 0x5520 and 0x5564, in that order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pc | output | 32 | Address of the word being fetched this cycle |
| wb_en | output | 1 | A register is written this cycle |
| wb_idx | output | 5 | Index of the register being written |
| wb_data | output | 32 | Value being written |

## Verification
The bench runs a generated program over only four registers, so dependences at distances one, two and three are frequent. It also runs back-to-back writes to one register, so the execute and memory stages often hold the same destination. If the stage priority were reversed, the older value would be written back. If the same-cycle bypass in the register file were missing, a consumer three instructions behind its producer would see a stale value. A missing zero-extension shows up as set upper bits whenever an immediate has bit 15 high. Writes to register 0 and unknown opcodes must leave no pulse at the port, and no later read may see any change from them. A reset in the middle of the run must leave the next pass reading cleared registers.

// File: rtl/pipe_pkg.sv
package pipe_pkg;

    localparam int XLEN     = 32;
    localparam int REG_CNT  = 32;
    localparam int RIDX_W   = $clog2(REG_CNT);
    localparam int IMM_W    = 16;
    localparam int OPC_W    = 6;

    localparam logic [OPC_W-1:0] OPC_ORI = 6'b001101;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    typedef enum logic { ALU_NONE = 1'b0, ALU_OR = 1'b1 } alu_e;

    // Decode -> execute payload
    typedef struct packed {
        logic  wr;
        ridx_t dst;
        alu_e  alu;
        word_t opa;
        word_t opb;
    } issue_t;

    // Result travelling execute -> memory -> write-back
    typedef struct packed {
        logic  wr;
        ridx_t dst;
        word_t val;
    } result_t;

    localparam issue_t  ISSUE_IDLE  = '{wr: 1'b0, dst: '0, alu: ALU_NONE, opa: '0, opb: '0};
    localparam result_t RESULT_IDLE = '{wr: 1'b0, dst: '0, val: '0};

    function automatic logic [OPC_W-1:0] f_opcode(input word_t w);
        return w[31:26];
    endfunction

    function automatic ridx_t f_src(input word_t w);
        return w[25:21];
    endfunction

    function automatic ridx_t f_dst(input word_t w);
        return w[20:16];
    endfunction

    function automatic word_t f_imm_zext(input word_t w);
        return {{(XLEN-IMM_W){1'b0}}, w[IMM_W-1:0]};
    endfunction

    // Youngest producer wins; index 0 is never forwarded.
    function automatic word_t f_pick_operand(input ridx_t idx, input result_t ex,
                                             input result_t mem, input word_t rf);
        if (idx == '0)                        return '0;
        else if (ex.wr && ex.dst == idx)      return ex.val;
        else if (mem.wr && mem.dst == idx)    return mem.val;
        else                                  return rf;
    endfunction

endpackage

// File: rtl/pipe_fetch.sv
module pipe_fetch
    import pipe_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter logic [IMEM_WORDS-1:0][XLEN-1:0] PROGRAM = '0
) (
    input  logic  clk,
    input  logic  rst,
    output word_t pc,
    output word_t fetch_word,
    output word_t dec_word
);
    localparam int AW = $clog2(IMEM_WORDS);

    word_t pc_q;
    word_t dec_q;
    logic  in_range;

    assign in_range   = (pc_q[XLEN-1:AW+2] == '0);
    assign fetch_word = in_range ? PROGRAM[pc_q[AW+1:2]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            dec_q <= '0;
        end else begin
            pc_q  <= pc_q + word_t'(4);
            dec_q <= fetch_word;
        end
    end

    assign pc       = pc_q;
    assign dec_word = dec_q;
endmodule

// File: rtl/pipe_regfile.sv
module pipe_regfile
    import pipe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t raddr,
    output word_t rdata,
    input  logic  we,
    input  ridx_t waddr,
    input  word_t wdata
);
    word_t bank [REG_CNT];

    assign bank[0] = '0;

    for (genvar g = 1; g < REG_CNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (we && waddr == ridx_t'(g))
                bank[g] <= wdata;
        end
    end

    // Same-cycle write passes straight to the reader
    always_comb begin
        if (raddr == '0)
            rdata = '0;
        else if (we && waddr == raddr)
            rdata = wdata;
        else
            rdata = bank[raddr];
    end
endmodule

// File: rtl/pipe_decode.sv
module pipe_decode
    import pipe_pkg::*;
(
    input  logic    rst,
    input  word_t   word,
    input  word_t   rf_rdata,
    input  result_t ex_fwd,
    input  result_t mem_fwd,
    output ridx_t   rf_raddr,
    output issue_t  issue
);
    logic is_ori;

    assign is_ori   = (f_opcode(word) == OPC_ORI);
    assign rf_raddr = f_src(word);

    always_comb begin
        issue = ISSUE_IDLE;
        if (!rst && is_ori) begin
            issue.wr  = (f_dst(word) != '0);
            issue.dst = f_dst(word);
            issue.alu = ALU_OR;
            issue.opa = f_pick_operand(f_src(word), ex_fwd, mem_fwd, rf_rdata);
            issue.opb = f_imm_zext(word);
        end
    end
endmodule

// File: rtl/pipe5_ori.sv
module pipe5_ori
    import pipe_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter logic [IMEM_WORDS-1:0][XLEN-1:0] PROGRAM =
        {{((IMEM_WORDS-4)*XLEN){1'b0}},
         32'h3421_0044, 32'h3421_4400, 32'h3421_0020, 32'h3401_1100}
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   pc,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]   wb_data
);
    word_t   fetch_word;
    word_t   dec_word;
    word_t   rf_rdata;
    ridx_t   rf_raddr;
    issue_t  dec_issue;
    issue_t  ex_q;
    result_t ex_res;
    result_t mem_q;
    result_t wb_q;

    pipe_fetch #(.IMEM_WORDS(IMEM_WORDS), .PROGRAM(PROGRAM)) u_fetch (
        .clk(clk), .rst(rst), .pc(pc), .fetch_word(fetch_word), .dec_word(dec_word)
    );

    pipe_decode u_decode (
        .rst(rst), .word(dec_word), .rf_rdata(rf_rdata),
        .ex_fwd(ex_res), .mem_fwd(mem_q),
        .rf_raddr(rf_raddr), .issue(dec_issue)
    );

    pipe_regfile u_rf (
        .clk(clk), .rst(rst), .raddr(rf_raddr), .rdata(rf_rdata),
        .we(wb_q.wr), .waddr(wb_q.dst), .wdata(wb_q.val)
    );

    // Execute stage
    always_comb begin
        ex_res.wr  = ex_q.wr;
        ex_res.dst = ex_q.dst;
        ex_res.val = (ex_q.alu == ALU_OR) ? (ex_q.opa | ex_q.opb) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_q  <= ISSUE_IDLE;
            mem_q <= RESULT_IDLE;
            wb_q  <= RESULT_IDLE;
        end else begin
            ex_q  <= dec_issue;
            mem_q <= ex_res;
            wb_q  <= mem_q;
        end
    end

    assign wb_en   = wb_q.wr;
    assign wb_idx  = wb_q.dst;
    assign wb_data = wb_q.val;
endmodule

// File: rtl/pipe5_ori_chk.sv
module pipe5_ori_chk
    import pipe_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input word_t pc,
    input logic  wb_en,
    input ridx_t wb_idx,
    input word_t wb_data,
    input word_t fetch_word
);
    logic [2:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)           cyc <= '0;
        else if (cyc != 4) cyc <= cyc + 3'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!wb_en && pc == '0)); // R8

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pc == $past(pc) + word_t'(4))); // R9

    AST_WB_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4) |-> (wb_en == (($past(fetch_word, 4) >> 26) == word_t'(OPC_ORI)
                                     && $past(fetch_word[20:16], 4) != '0))); // R7

    AST_WB_DEST: assert property (@(posedge clk) disable iff (rst)
        (cyc == 3'd4 && wb_en) |-> (wb_idx == $past(fetch_word[20:16], 4))); // R1

    AST_NO_R0_WRITE: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_idx != '0)); // R6

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_data[31:16] == '0)); // R2
endmodule

bind pipe5_ori pipe5_ori_chk u_chk (
    .clk(clk), .rst(rst), .pc(pc), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .fetch_word(fetch_word)
);

// File: tb/sim_pipe5_ori.sv
module sim_pipe5_ori;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;

    function automatic logic [WORDS-1:0][31:0] build_prog();
        logic [WORDS-1:0][31:0] p;
        logic [31:0] s;
        logic [5:0]  op;
        p    = '0;
        s    = 32'h1234_5678;
        p[0] = 32'h3401_1100;
        p[1] = 32'h3421_0020;
        p[2] = 32'h3421_4400;
        p[3] = 32'h3421_0044;
        for (int i = 4; i < WORDS; i++) begin
            s  = s * 32'd1103515245 + 32'd12345;
            op = (s[22:20] == 3'd0) ? (s[23] ? 6'h0c : 6'h00) : 6'b001101;
            p[i] = {op, 3'b000, s[17:16], 3'b000, s[19:18], s[15:0] ^ s[31:16]};
        end
        return p;
    endfunction

    localparam logic [WORDS-1:0][31:0] PROG = build_prog();

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;

    int checks = 0;
    int bad    = 0;
    logic [31:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe5_ori #(.IMEM_WORDS(WORDS), .PROGRAM(PROG)) u0 (
        .clk(clk), .rst(rst), .pc(pc), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] word_at(input int j);
        return (j >= 0 && j < WORDS) ? PROG[j] : 32'h0;
    endfunction

    function automatic string dep_tag(input int j, input logic [4:0] rs);
        for (int d = 1; d <= 3; d++) begin
            if (j - d >= 0 && word_at(j-d)[31:26] == 6'b001101
                && word_at(j-d)[20:16] == rs && rs != 0)
                return (d == 1) ? "R3" : (d == 2) ? "R4" : "R5";
        end
        return (rs == 0) ? "R6" : "R1";
    endfunction

    task automatic run_phase(input int ncyc, input bit first);
        logic [31:0] chain [4];
        chain[0] = 32'h1100; chain[1] = 32'h1120; chain[2] = 32'h5520; chain[3] = 32'h5564;
        for (int r = 0; r < 32; r++) model[r] = '0;
        for (int k = 0; k <= ncyc; k++) begin
            int          j;
            logic [31:0] w;
            logic        exp_en;
            logic [31:0] exp_val;
            string       tag;
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            check(pc == 32'(4*k), "R9", "pc", pc, 32'(4*k));
            j = k - 4;
            w = word_at(j);
            exp_en  = 1'b0;
            exp_val = '0;
            if (j < 0)                          tag = "R8";
            else if (w[31:26] != 6'b001101)     tag = "R7";
            else if (w[20:16] == 0)             tag = "R6";
            else begin
                exp_en  = 1'b1;
                exp_val = model[w[25:21]] | {16'h0, w[15:0]};
                model[w[20:16]] = exp_val;
                tag = dep_tag(j, w[25:21]);
                if (tag == "R1" && w[15]) tag = "R2";
                if (first && j < 4) tag = "R10";
            end
            check(wb_en == exp_en, tag, "wb_en", 32'(wb_en), 32'(exp_en));
            if (exp_en) begin
                check(wb_idx == w[20:16], tag, "wb_idx", 32'(wb_idx), 32'(w[20:16]));
                check(wb_data == exp_val, tag, "wb_data", wb_data, exp_val);
                if (first && j < 4)
                    check(wb_data == chain[j], "R10", "chain value", wb_data, chain[j]);
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!wb_en, "R8", "wb_en in reset", 32'(wb_en), 32'h0);
        check(pc == 0, "R8", "pc in reset", pc, 32'h0);
        rst = 1'b0;
        run_phase(30, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!wb_en, "R8", "wb_en after mid-run reset", 32'(wb_en), 32'h0);
        check(pc == 0, "R8", "pc after mid-run reset", pc, 32'h0);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_phase(WORDS + 6, 1'b0);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule